// File: doc/BRIEF.md
# Asynchronous PSRAM Access Controller

This block sits between a clocked host and an asynchronous pseudo-static RAM of 256K words by 16 bits. The host presents one request at a time through a request/ready handshake: a write flag, an 18-bit word address, 16-bit write data and a two-bit byte-lane enable. Reads return their data on a one-cycle response pulse. On the memory side the controller drives the chip selects, output enable, write enable and the per-byte enables, all active low except the second chip select. It also drives the address and a split data bus (output value, output enable and input value) that a pad ring turns into the tri-state pins.

Every memory timing interval is a count of clock cycles. The counts are derived from nanosecond parameters and the clock period, rounded up, with a minimum of one cycle. The controller is a single state machine with six states. IDLE accepts requests. GAP holds the chip deselected so the memory can refresh internally. TURN is an idle cycle for bus turnaround. READ holds the read strobes. WR_PULSE holds write enable low and drives the data. WR_RECOVER completes the write cycle.

The transitions are as follows. IDLE goes to GAP when a read is due for a refresh gap. It goes to READ for any other read with lanes enabled. It goes to TURN for a write that follows a read, and to WR_PULSE for any other write. IDLE stays put for a request with no lanes enabled. GAP goes to READ, TURN goes to WR_PULSE, READ returns to IDLE, WR_PULSE goes to WR_RECOVER, and WR_RECOVER returns to IDLE. Each of these steps is taken when the interval timer reaches its last cycle.

Top module: `psram_ctrl`

## Requirements
- R1: While reset is low, chip select 1, output enable, write enable and both byte enables are high, chip select 2 is low, the data bus is not driven, and ready and the response valid are low. From the second cycle after reset release onward, chip select 2 stays high and ready is high in IDLE.
- R2: A read request with lanes enabled is accepted on a clock edge where request and ready are both high. The controller then holds chip select 1 low, output enable low and write enable high for N_RC cycles, with the request's address on the memory address lines. N_RC = ceil(55 ns / clock period) = 7 at 8 ns.
- R3: Read data is sampled on the clock edge that ends the last READ cycle. In the following cycle the response valid is high for exactly one cycle, ready is high, and the response data holds the sampled value with the bytes of disabled lanes forced to zero.
- R4: Byte-enable bit 0 selects data bits 7:0 and drives memory byte enable bit 0 low. Bit 1 selects bits 15:8 and drives memory byte enable bit 1 low. These levels hold for every cycle that chip select 1 is low, and only the selected bytes of the memory are written.
- R5: A write holds write enable low for N_WP = max(ceil(40/T), ceil(45/T), ceil(25/T)) = 6 cycles, with chip select 1 low and the data bus driven with the write data. It then holds chip select 1 low and write enable high for N_WR = max(1, ceil(55/T) − N_WP) = 1 cycle, with the bus released. Output enable stays high throughout, and the bus is driven only while write enable is low.
- R6: A write whose previous completed access was a read is preceded by one TURN cycle with every strobe inactive and ready low.
- R7: A request with both lanes disabled is accepted without any strobe. The memory keeps its contents. A read returns response valid in the next cycle with data zero.
- R8: A run counter counts cycles and clears when chip select 1 has been high for N_RC consecutive cycles. Before a read starts, if run + N_RC + 1 > N_BURST, with N_BURST = floor(15000 ns / T) = 1875, chip select 1 is first held high for N_RC GAP cycles with ready low.
- R9: Ready is high only in IDLE and low whenever chip select 1 is low. Each accepted request produces exactly one memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request |
| ready | output | 1 | Controller can accept a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables, bit 0 = low byte |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_ce1_n | output | 1 | Chip select 1, active low |
| mem_ce2 | output | 1 | Chip select 2, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | 2 | Byte enables, active low, bit 0 = low byte |
| mem_addr | output | 18 | Memory address |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
A wrong state or a timer loaded with the wrong value shows at the strobes in the same cycle. A strobe that is too long or too short, a missing TURN or GAP cycle, or a lane enable that drops out mid-access is visible right away, because every state maps directly onto the memory pins. A fault in the run counter shows only after a long read burst, as a refresh gap that comes too early or too late. A fault in data capture or lane masking shows one cycle after the read ends, on the response data. The bench therefore compares every pin in every cycle against an expected waveform and runs a burst long enough to force the refresh gap.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_TURN,
        ST_READ,
        ST_WR_PULSE,
        ST_WR_RECOVER
    } psram_state_e;

    // Nanoseconds to clock cycles, rounded up, never below one.
    function automatic int ns2cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_interval_timer.sv
module psram_interval_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == W'(1));
endmodule

// File: rtl/psram_refresh_guard.sv
module psram_refresh_guard #(
    parameter int N_RC    = 7,
    parameter int N_BURST = 1875
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce1_n,
    output logic due
);
    localparam int RUN_W = $clog2(N_BURST + 1);
    localparam int HI_W  = $clog2(N_RC + 1);

    logic [HI_W-1:0]  hi_q;
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_inc;

    assign run_inc = (int'(run_q) >= N_BURST) ? run_q : run_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q  <= '0;
            run_q <= '0;
        end else if (ce1_n) begin
            hi_q <= (hi_q == HI_W'(N_RC)) ? hi_q : hi_q + 1'b1;
            if (int'(hi_q) + 1 >= N_RC)
                run_q <= '0;
            else
                run_q <= run_inc;
        end else begin
            hi_q  <= '0;
            run_q <= run_inc;
        end
    end

    // Starting a read now could carry the run past the window.
    assign due = (int'(run_q) + N_RC + 1) > N_BURST;
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 8,
    parameter int ADDR_W        = 18,
    parameter int DATA_W        = 16,
    parameter int T_RC_NS       = 55,
    parameter int T_WC_NS       = 55,
    parameter int T_PWE_NS      = 40,
    parameter int T_AW_NS       = 45,
    parameter int T_SD_NS       = 25,
    parameter int T_BURST_NS    = 15000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req,
    output logic                   ready,
    input  logic                   req_we,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    input  logic [DATA_W/8-1:0]    req_be,
    output logic                   rsp_valid,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic                   mem_ce1_n,
    output logic                   mem_ce2,
    output logic                   mem_oe_n,
    output logic                   mem_we_n,
    output logic [DATA_W/8-1:0]    mem_be_n,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [DATA_W-1:0]      mem_dq_out,
    output logic                   mem_dq_oe,
    input  logic [DATA_W-1:0]      mem_dq_in
);
    localparam int LANES   = DATA_W / 8;
    localparam int N_RC    = ns2cyc(T_RC_NS, CLK_PERIOD_NS);
    localparam int N_WP    = imax(ns2cyc(T_PWE_NS, CLK_PERIOD_NS),
                             imax(ns2cyc(T_AW_NS, CLK_PERIOD_NS),
                                  ns2cyc(T_SD_NS, CLK_PERIOD_NS)));
    localparam int N_WR    = imax(1, ns2cyc(T_WC_NS, CLK_PERIOD_NS) - N_WP);
    localparam int N_BURST = T_BURST_NS / CLK_PERIOD_NS;
    localparam int TMR_W   = $clog2(imax(N_RC, imax(N_WP, N_WR)) + 1);

    psram_state_e state_q, state_d;

    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_last;
    logic              gap_due;
    logic              active_q;
    logic              last_rd_q;
    logic              accept;
    logic              no_lanes;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  be_q;
    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;

    psram_interval_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    psram_refresh_guard #(.N_RC(N_RC), .N_BURST(N_BURST)) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .ce1_n (mem_ce1_n),
        .due   (gap_due)
    );

    // Byte lane expansion of the captured enables
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_mask[g*8 +: 8] = {8{be_q[g]}};
    end

    assign accept   = req && ready;
    assign no_lanes = (req_be == '0);

    // Next state and interval timer load
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && !no_lanes) begin
                    tmr_load = 1'b1;
                    if (!req_we) begin
                        state_d = gap_due ? ST_GAP : ST_READ;
                        tmr_val = TMR_W'(N_RC);
                    end else if (last_rd_q) begin
                        state_d = ST_TURN;
                        tmr_val = TMR_W'(1);
                    end else begin
                        state_d = ST_WR_PULSE;
                        tmr_val = TMR_W'(N_WP);
                    end
                end
            end
            ST_GAP: begin
                if (tmr_last) begin
                    state_d  = ST_READ;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(N_RC);
                end
            end
            ST_TURN: begin
                if (tmr_last) begin
                    state_d  = ST_WR_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(N_WP);
                end
            end
            ST_READ: begin
                if (tmr_last) state_d = ST_IDLE;
            end
            ST_WR_PULSE: begin
                if (tmr_last) begin
                    state_d  = ST_WR_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(N_WR);
                end
            end
            ST_WR_RECOVER: begin
                if (tmr_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Request capture, read capture and access history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q  <= 1'b0;
            last_rd_q <= 1'b0;
            addr_q    <= '0;
            wdata_q   <= '0;
            be_q      <= '0;
            rdata_q   <= '0;
            rvalid_q  <= 1'b0;
        end else begin
            active_q <= 1'b1;
            rvalid_q <= 1'b0;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                be_q    <= req_be;
                if (no_lanes && !req_we) begin
                    rvalid_q <= 1'b1;
                    rdata_q  <= '0;
                end
            end
            if (state_q == ST_READ && tmr_last) begin
                rdata_q   <= mem_dq_in & lane_mask;
                rvalid_q  <= 1'b1;
                last_rd_q <= 1'b1;
            end
            if (state_q == ST_WR_RECOVER && tmr_last)
                last_rd_q <= 1'b0;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        mem_ce1_n = 1'b1;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_be_n  = '1;
        mem_dq_oe = 1'b0;
        ready     = 1'b0;
        unique case (state_q)
            ST_IDLE:       ready = active_q;
            ST_GAP:        ;
            ST_TURN:       ;
            ST_READ: begin
                mem_ce1_n = 1'b0;
                mem_oe_n  = 1'b0;
                mem_be_n  = ~be_q;
            end
            ST_WR_PULSE: begin
                mem_ce1_n = 1'b0;
                mem_we_n  = 1'b0;
                mem_be_n  = ~be_q;
                mem_dq_oe = 1'b1;
            end
            ST_WR_RECOVER: begin
                mem_ce1_n = 1'b0;
                mem_be_n  = ~be_q;
            end
            default: ;
        endcase
    end

    assign mem_ce2    = active_q;
    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign rsp_valid  = rvalid_q;
    assign rsp_rdata  = rdata_q;
endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk
    import psram_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 8,
    parameter int T_RC_NS       = 55,
    parameter int T_PWE_NS      = 40,
    parameter int T_AW_NS       = 45,
    parameter int T_SD_NS       = 25,
    parameter int T_BURST_NS    = 15000
) (
    input logic clk,
    input logic rst_n,
    input logic mem_ce1_n,
    input logic mem_ce2,
    input logic mem_oe_n,
    input logic mem_we_n,
    input logic mem_dq_oe,
    input logic ready,
    input logic rsp_valid
);
    localparam int N_RC    = ns2cyc(T_RC_NS, CLK_PERIOD_NS);
    localparam int N_WP    = imax(ns2cyc(T_PWE_NS, CLK_PERIOD_NS),
                             imax(ns2cyc(T_AW_NS, CLK_PERIOD_NS),
                                  ns2cyc(T_SD_NS, CLK_PERIOD_NS)));
    localparam int N_BURST = T_BURST_NS / CLK_PERIOD_NS;

    int we_low_q;
    int ce_low_q;
    int hi_q;
    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_q <= 0;
            ce_low_q <= 0;
            hi_q     <= 0;
            run_q    <= 0;
        end else begin
            we_low_q <= mem_we_n  ? 0 : we_low_q + 1;
            ce_low_q <= mem_ce1_n ? 0 : ce_low_q + 1;
            if (mem_ce1_n) begin
                hi_q  <= hi_q + 1;
                run_q <= (hi_q + 1 >= N_RC) ? 0 : run_q + 1;
            end else begin
                hi_q  <= 0;
                run_q <= run_q + 1;
            end
        end
    end

    assert_ce2_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> mem_ce2);

    assert_read_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_ce1_n) && $past(!mem_oe_n)) |-> (ce_low_q >= N_RC));

    assert_rvalid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_no_oe_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    assert_drive_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && !mem_ce1_n && mem_ce2));

    assert_we_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_q >= N_WP));

    assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!mem_oe_n) |-> !mem_dq_oe);

    assert_burst_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce1_n && !mem_oe_n) |-> (run_q <= N_BURST));

    assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce1_n |-> !ready);
endmodule

bind psram_ctrl psram_ctrl_chk #(
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .T_RC_NS       (T_RC_NS),
    .T_PWE_NS      (T_PWE_NS),
    .T_AW_NS       (T_AW_NS),
    .T_SD_NS       (T_SD_NS),
    .T_BURST_NS    (T_BURST_NS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_ce1_n (mem_ce1_n),
    .mem_ce2   (mem_ce2),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe),
    .ready     (ready),
    .rsp_valid (rsp_valid)
);

// File: tb/sim_psram_ctrl.sv
module sim_psram_ctrl;
    localparam int N_RC    = 7;
    localparam int N_WP    = 6;
    localparam int N_WR    = 1;
    localparam int N_BURST = 1875;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        ready;
    logic        req_we = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [1:0]  mem_be_n;
    logic [17:0] mem_addr;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = '0;

    always #4 clk = ~clk;

    psram_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    typedef struct {
        bit        ce1, we, oe, dqoe, rdy, rv;
        bit [1:0]  be_n;
        bit [17:0] addr;
        bit [15:0] dq, rdata;
        string     tag;
    } vec_t;

    vec_t        expq[$];
    int          vectors = 0;
    int          miscompares = 0;
    int          acc_cnt = 0;
    int          gaps = 0;
    int          since_rel = 0;
    int          hi = 0, run = 0;
    bit          last_rd = 0;
    logic [15:0] shadow  [int];
    logic [15:0] busmem  [int];

    function automatic logic [15:0] rd_arr(input logic [15:0] m [int], input int a);
        return m.exists(a) ? m[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic vec_t idle_vec(input bit rdy, input string tag);
        vec_t v;
        v.ce1 = 1; v.we = 1; v.oe = 1; v.dqoe = 0; v.rdy = rdy; v.rv = 0;
        v.be_n = 2'b11; v.addr = '0; v.dq = '0; v.rdata = '0; v.tag = tag;
        return v;
    endfunction

    task automatic cmp(input string what, input string tag, input int act, input int exp);
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s at %0t: actual %0h expected %0h", tag, what, $time, act, exp);
        end
    endtask

    // Memory bus model: reads on each negedge, writes lanes while write enable is low
    always @(negedge clk) begin
        if (!mem_ce1_n && mem_ce2 && !mem_we_n && mem_dq_oe) begin
            logic [15:0] w;
            w = rd_arr(busmem, int'(mem_addr));
            if (!mem_be_n[0]) w[7:0]  = mem_dq_out[7:0];
            if (!mem_be_n[1]) w[15:8] = mem_dq_out[15:8];
            busmem[int'(mem_addr)] = w;
        end
        if (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n) begin
            logic [15:0] r;
            r = rd_arr(busmem, int'(mem_addr));
            mem_dq_in <= {mem_be_n[1] ? 8'hA5 : r[15:8], mem_be_n[0] ? 8'h5A : r[7:0]};
        end else begin
            mem_dq_in <= 16'hC33C;
        end
    end

    // Reference model: expected pins per cycle, compared on every negedge
    always @(negedge clk) begin
        if (!rst_n) begin
            vectors++;
            cmp("ce1_n", "R1", int'(mem_ce1_n), 1);
            cmp("oe_n",  "R1", int'(mem_oe_n), 1);
            cmp("we_n",  "R1", int'(mem_we_n), 1);
            cmp("be_n",  "R1", int'(mem_be_n), 3);
            cmp("ce2",   "R1", int'(mem_ce2), 0);
            cmp("dq_oe", "R1", int'(mem_dq_oe), 0);
            cmp("ready", "R1", int'(ready), 0);
            cmp("rvalid","R1", int'(rsp_valid), 0);
            expq.delete();
            hi = 0; run = 0; last_rd = 0; since_rel = 0;
        end else begin
            vec_t cur;
            cur = (expq.size() > 0) ? expq.pop_front() : idle_vec(since_rel > 0, "R9");
            vectors++;
            cmp("ce2",    "R1", int'(mem_ce2), (since_rel > 0) ? 1 : 0);
            cmp("ce1_n",  cur.tag, int'(mem_ce1_n), int'(cur.ce1));
            cmp("we_n",   cur.tag, int'(mem_we_n), int'(cur.we));
            cmp("oe_n",   cur.tag, int'(mem_oe_n), int'(cur.oe));
            cmp("be_n",   "R4", int'(mem_be_n), int'(cur.be_n));
            cmp("dq_oe",  cur.tag, int'(mem_dq_oe), int'(cur.dqoe));
            cmp("ready",  cur.tag, int'(ready), int'(cur.rdy));
            cmp("rvalid", cur.tag, int'(rsp_valid), int'(cur.rv));
            if (!cur.ce1) cmp("addr", "R2", int'(mem_addr), int'(cur.addr));
            if (cur.dqoe) cmp("dq_out", "R5", int'(mem_dq_out), int'(cur.dq));
            if (cur.rv)   cmp("rdata", cur.tag, int'(rsp_rdata), int'(cur.rdata));

            if (req && cur.rdy) begin
                vec_t v;
                acc_cnt++;
                if (req_be == 2'b00) begin
                    v = idle_vec(1, "R7");
                    if (!req_we) begin v.rv = 1; v.rdata = 16'h0000; end
                    expq.push_back(v);
                end else if (!req_we) begin
                    if (run + N_RC + 1 > N_BURST) begin
                        gaps++;
                        for (int i = 0; i < N_RC; i++) expq.push_back(idle_vec(0, "R8"));
                    end
                    v = idle_vec(0, "R2");
                    v.ce1 = 0; v.oe = 0; v.be_n = ~req_be; v.addr = req_addr;
                    for (int i = 0; i < N_RC; i++) expq.push_back(v);
                    v = idle_vec(1, "R3");
                    v.rv = 1;
                    v.rdata = rd_arr(shadow, int'(req_addr)) & lane_mask(req_be);
                    expq.push_back(v);
                    last_rd = 1;
                end else begin
                    logic [15:0] w;
                    if (last_rd) expq.push_back(idle_vec(0, "R6"));
                    v = idle_vec(0, "R5");
                    v.ce1 = 0; v.we = 0; v.be_n = ~req_be; v.addr = req_addr;
                    v.dqoe = 1; v.dq = req_wdata;
                    for (int i = 0; i < N_WP; i++) expq.push_back(v);
                    v.we = 1; v.dqoe = 0;
                    for (int i = 0; i < N_WR; i++) expq.push_back(v);
                    w = rd_arr(shadow, int'(req_addr));
                    w = (w & ~lane_mask(req_be)) | (req_wdata & lane_mask(req_be));
                    shadow[int'(req_addr)] = w;
                    last_rd = 0;
                end
            end

            // Run counter rule of R8, applied to this cycle's chip select
            if (cur.ce1) begin
                if (hi < N_RC) hi++;
                run = (hi >= N_RC) ? 0 : run + 1;
            end else begin
                hi = 0;
                run++;
            end
            since_rel++;
        end
    end

    task automatic issue(input bit we, input logic [17:0] a, input logic [15:0] d,
                         input logic [1:0] be);
        int start;
        start     = acc_cnt;
        req       = 1'b1;
        req_we    = we;
        req_addr  = a;
        req_wdata = d;
        req_be    = be;
        while (acc_cnt == start) begin
            @(posedge clk);
            #1;
        end
        req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog R9: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R5 full write, then R2/R3 read back
        issue(1, 18'h00020, 16'hABCD, 2'b11);
        issue(0, 18'h00020, 16'h0000, 2'b11);
        // R6 write after read; R4 single lanes
        issue(1, 18'h00020, 16'h5566, 2'b01);
        issue(1, 18'h00020, 16'h7788, 2'b10);
        issue(0, 18'h00020, 16'h0000, 2'b11);
        issue(0, 18'h00020, 16'h0000, 2'b01);
        issue(0, 18'h00020, 16'h0000, 2'b10);
        // R7 no lanes: write ignored, read returns zero
        issue(1, 18'h00020, 16'hFFFF, 2'b00);
        issue(0, 18'h00020, 16'h0000, 2'b00);
        issue(0, 18'h00020, 16'h0000, 2'b11);
        // top address
        issue(1, 18'h3FFFF, 16'hBEEF, 2'b11);
        issue(0, 18'h3FFFF, 16'h0000, 2'b11);
        // R8 long read burst forces a refresh gap
        for (int i = 0; i < 250; i++)
            issue(0, (i % 2) ? 18'h3FFFF : 18'h00020, 16'h0000, 2'b11);
        issue(1, 18'h00100, 16'h1357, 2'b11);
        issue(0, 18'h00100, 16'h0000, 2'b11);
        repeat (30) @(posedge clk);
        #1;
        vectors++;
        if (gaps == 0) begin
            miscompares++;
            $display("FAIL R8 burst: actual %0d gaps expected at least 1", gaps);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule